// File: doc/BRIEF.md
# NAND Flash Section-Mapped Bus Bridge

This block lets a host drive an 8-bit NAND flash device using nothing but ordinary loads and stores. Two host address bits pick the kind of NAND cycle. A store into the command window puts a command byte on the bus with the command latch enable high. A store into the address window puts one address byte on the bus with the address latch enable high. A full NAND address is just four or five such stores in a row. Loads and stores into the data window become plain data cycles. The device steps its own column pointer, so the offset inside a window does not matter.

Each NAND cycle runs as a fixed sequence. Chip enable goes low and the latch enables and data are set up for a programmable count. Then the write or read strobe goes low for a programmable width. Then everything is held for a programmable count. The bridge then raises the host ready signal for one cycle. On the host side, the request is a level: it stays high, with address, direction and write data held stable, until ready is seen. A new request made while a cycle is in progress simply waits, so nothing is lost. An optional mode holds data-window accesses back while the device's ready/busy line is low.

The state machine has these states: `ST_IDLE`, `ST_WAIT_RB`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD` and `ST_DONE`. Its transitions are:
- IDLE→DONE: a read of the command or address window.
- IDLE→WAIT_RB: a data access while busy-wait is on and ready/busy is low.
- IDLE→SETUP: any other request.
- WAIT_RB→SETUP: ready/busy goes high.
- SETUP→STROBE: the setup count runs out.
- STROBE→HOLD: the strobe count runs out. Read data is captured on this edge.
- HOLD→DONE: the hold count runs out.
- DONE→IDLE: always, after one cycle.

Top module: `nand_section_bridge`

## Requirements
- R1: Host address bits [17:16] select the window. The value 00 is data, 01 is command, and any value with bit 17 set is address. All lower address bits are ignored. CLE and ALE are never high together.
- R2: A store to the command window drives the write byte on `nand_dq_out` with `nand_dq_oe`=1, `nand_cle`=1 and `nand_ale`=0, and pulses `nand_we_n` low.
- R3: A store to the address window drives the byte with `nand_ale`=1 and `nand_cle`=0, and pulses `nand_we_n` low. Consecutive address stores each produce exactly one such cycle.
- R4: A store to the data window pulses `nand_we_n` low with CLE=0, ALE=0 and `nand_dq_oe`=1. `nand_re_n` stays high.
- R5: A load from the data window pulses `nand_re_n` low with CLE=0, ALE=0 and `nand_dq_oe`=0. `host_rdata` returns the value of `nand_dq_in` captured when `nand_re_n` rises, and it stays valid while ready is high.
- R6: Before the strobe, chip enable is low with both strobes high for exactly `cfg_setup`+1 cycles.
- R7: The strobe is low for exactly `cfg_strobe`+1 cycles, and only while chip enable is low.
- R8: After the strobe, chip enable stays low with both strobes high for exactly `cfg_hold`+1 cycles. Chip enable then goes high and `host_ready` is raised.
- R9: When `cfg_wait_rb`=1 and `nand_rb`=0, a data-window access leaves chip enable and both strobes high and ready low until `nand_rb` goes high. Command and address stores are never stalled. When `cfg_wait_rb`=0, `nand_rb` has no effect.
- R10: `host_ready` is high for exactly one cycle per request. A request held high during a cycle is served after that cycle finishes, never dropped.
- R11: A load from the command or address window makes no NAND cycle: chip enable stays high. It completes with ready and `host_rdata`=0.
- R12: During and right after reset, chip enable and both strobes are high, and CLE, ALE, `nand_dq_oe` and `host_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request level, held until ready |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 18 | Host byte address; bits [17:16] select the window |
| host_wdata | input | 8 | Store data |
| host_rdata | output | 8 | Load data, valid while ready is high |
| host_ready | output | 1 | One-cycle completion pulse |
| cfg_setup | input | 4 | Setup count (phase lasts value+1 cycles) |
| cfg_strobe | input | 4 | Strobe width count (value+1 cycles) |
| cfg_hold | input | 4 | Hold count (value+1 cycles) |
| cfg_wait_rb | input | 1 | Stall data-window accesses while ready/busy is low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven toward the device |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench uses the default parameters: an 18-bit host address, the window select at bit 16, an 8-bit data path and 4-bit counters. With 4-bit counters, the largest count of 15 is quick to reach, so the directed cases run the shortest timing (all zero) and the longest (all fifteen). The random mix draws counts from 0 to 15 and random low address bits, so every window is tested with offsets that the decoder must ignore. Keeping the counter width small also keeps busy-wait stalls and runs of back-to-back address stores short. That leaves room for many transactions inside the cycle budget.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
    typedef enum logic [1:0] {
        SEC_DATA = 2'd0,
        SEC_CMD  = 2'd1,
        SEC_ADDR = 2'd2
    } section_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RB,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } state_t;
endpackage

// File: rtl/nsb_decode.sv
module nsb_decode
    import nsb_pkg::*;
(
    input  logic [1:0] sel_bits,
    output section_t   sec
);
    // Bit 1 set wins: address window regardless of bit 0.
    always_comb begin
        if (sel_bits[1])      sec = SEC_ADDR;
        else if (sel_bits[0]) sec = SEC_CMD;
        else                  sec = SEC_DATA;
    end
endmodule

// File: rtl/nsb_timer.sv
module nsb_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nand_section_bridge.sv
module nand_section_bridge
    import nsb_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int SEL_LSB = 16,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_wait_rb,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb
);
    state_t            state, state_nx;
    section_t          sec_in, sec_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              unused_addr;

    // Only the window-select bits matter; the offset inside a window is dropped.
    assign unused_addr = ^host_addr;

    nsb_decode u_decode (
        .sel_bits (host_addr[SEL_LSB+1:SEL_LSB]),
        .sec      (sec_in)
    );

    nsb_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Next state and phase timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = cfg_setup;
        unique case (state)
            ST_IDLE: if (host_req) begin
                if (!host_we && sec_in != SEC_DATA) begin
                    state_nx = ST_DONE;
                end else if (cfg_wait_rb && sec_in == SEC_DATA && !nand_rb) begin
                    state_nx = ST_WAIT_RB;
                end else begin
                    state_nx = ST_SETUP;
                    tmr_load = 1'b1;
                end
            end
            ST_WAIT_RB: if (nand_rb) begin
                state_nx = ST_SETUP;
                tmr_load = 1'b1;
            end
            ST_SETUP: if (tmr_expired) begin
                state_nx = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = cfg_strobe;
            end
            ST_STROBE: if (tmr_expired) begin
                state_nx = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = cfg_hold;
            end
            ST_HOLD: if (tmr_expired) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sec_q   <= SEC_DATA;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && host_req) begin
                sec_q   <= sec_in;
                we_q    <= host_we;
                wdata_q <= host_wdata;
                if (!host_we) rdata_q <= '0;
            end
            // Capture on the edge that ends the read strobe
            if (state == ST_STROBE && tmr_expired && !we_q)
                rdata_q <= nand_dq_in;
        end
    end

    // Outputs from state
    always_comb begin
        logic active;
        active      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        nand_ce_n   = !active;
        nand_cle    = active && (sec_q == SEC_CMD);
        nand_ale    = active && (sec_q == SEC_ADDR);
        nand_we_n   = !((state == ST_STROBE) && we_q);
        nand_re_n   = !((state == ST_STROBE) && !we_q);
        nand_dq_oe  = active && we_q;
        nand_dq_out = wdata_q;
        host_ready  = (state == ST_DONE);
        host_rdata  = rdata_q;
    end

    // Assertions
    p_latch_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    p_write_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    p_rdata_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> $stable(host_rdata));
    p_strobe_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RB) |-> (nand_ce_n && nand_we_n && nand_re_n && !host_ready));
    p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
    p_ready_after_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> nand_ce_n);
endmodule

// File: tb/tb_nand_section_bridge.sv
`timescale 1ns/1ps
module tb_nand_section_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic [3:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic        cfg_wait_rb = 1'b0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b1;

    int checks = 0, failures = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    nand_section_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_hold(cfg_hold), .cfg_wait_rb(cfg_wait_rb), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Window code from address bits: 0 data, 1 command, 2 address
    function automatic int win_of(input logic [17:0] a);
        if (a[17]) return 2;
        if (a[16]) return 1;
        return 0;
    endfunction

    // Observed cycle record
    int n_setup, n_strobe, n_hold, n_ce;
    bit saw_we, saw_re, s_cle, s_ale, s_oe;
    logic [7:0] s_dq, got_rdata;

    task automatic issue(input logic [17:0] a, input bit we, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_we = we; host_wdata = d; host_req = 1'b1;
        n_setup = 0; n_strobe = 0; n_hold = 0; n_ce = 0;
        saw_we = 0; saw_re = 0; s_cle = 0; s_ale = 0; s_oe = 0; s_dq = '0;
    endtask

    task automatic finish_access();
        int guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (guard > 200) begin
                chk(0, "R10 access never completed", guard, 0);
                break;
            end
            if (host_ready) begin
                got_rdata = host_rdata;
                break;
            end
            if (!nand_ce_n) begin
                n_ce++;
                if (!nand_we_n || !nand_re_n) begin
                    n_strobe++;
                    saw_we |= !nand_we_n; saw_re |= !nand_re_n;
                    s_cle = nand_cle; s_ale = nand_ale; s_oe = nand_dq_oe; s_dq = nand_dq_out;
                end else if (n_strobe == 0) n_setup++;
                else n_hold++;
            end else if (!nand_we_n || !nand_re_n) begin
                chk(0, "R7 strobe without chip enable", 1, 0);
            end
        end
        host_req = 1'b0;
        @(negedge clk);
        chk(!host_ready, "R10 ready one cycle", host_ready, 0);
    endtask

    task automatic verify(input logic [17:0] a, input bit we, input logic [7:0] d,
                          input logic [7:0] bus_in);
        int w = win_of(a);
        if (!we && w != 0) begin
            chk(n_ce == 0, "R11 no cycle on control-window load", n_ce, 0);
            chk(got_rdata == 8'h00, "R11 rdata zero", got_rdata, 0);
            return;
        end
        chk(n_setup == cfg_setup + 1, "R6 setup length", n_setup, cfg_setup + 1);
        chk(n_strobe == cfg_strobe + 1, "R7 strobe width", n_strobe, cfg_strobe + 1);
        chk(n_hold == cfg_hold + 1, "R8 hold length", n_hold, cfg_hold + 1);
        chk(s_cle == (w == 1), "R1 cle by window", s_cle, w == 1);
        chk(s_ale == (w == 2), "R1 ale by window", s_ale, w == 2);
        if (we) begin
            chk(saw_we && !saw_re, w == 1 ? "R2 we strobe" : (w == 2 ? "R3 we strobe" : "R4 we strobe"),
                {saw_we, saw_re}, 2);
            chk(s_oe && s_dq == d, w == 1 ? "R2 command byte" : (w == 2 ? "R3 address byte" : "R4 data byte"),
                s_dq, d);
        end else begin
            chk(saw_re && !saw_we && !s_oe, "R5 read strobe", {saw_we, saw_re, s_oe}, 2);
            chk(got_rdata == bus_in, "R5 read data", got_rdata, bus_in);
        end
    endtask

    task automatic access(input logic [17:0] a, input bit we, input logic [7:0] d,
                          input logic [7:0] bus_in);
        nand_dq_in = bus_in;
        issue(a, we, d);
        finish_access();
        verify(a, we, d, bus_in);
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "R10 watchdog expired", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !host_ready,
            "R12 reset outputs", {nand_ce_n, nand_we_n, nand_re_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(nand_ce_n && !host_ready, "R12 after reset", nand_ce_n, 1);

        // Directed: fastest timing
        access(18'h1_0000, 1, 8'h70, 8'h00);     // command
        access(18'h2_0000, 1, 8'h11, 8'h00);     // address
        access(18'h0_0000, 1, 8'hA5, 8'h00);     // data store
        access(18'h0_00FF, 0, 8'h00, 8'h3C);     // data load
        // Slowest timing
        cfg_setup = 4'd15; cfg_strobe = 4'd15; cfg_hold = 4'd15;
        access(18'h1_FFFF, 1, 8'h90, 8'h00);
        access(18'h0_1234, 0, 8'h00, 8'hC3);
        // R3 five consecutive address stores with offsets, bit 16 set too
        cfg_setup = 4'd1; cfg_strobe = 4'd2; cfg_hold = 4'd0;
        for (int i = 0; i < 5; i++)
            access(18'h3_0000 | 18'(i * 37), 1, 8'(8'h20 + i), 8'h00);
        // R11 loads from control windows
        access(18'h1_0040, 0, 8'h00, 8'h77);
        access(18'h2_0040, 0, 8'h00, 8'h77);

        // R9 busy stall on data window
        cfg_wait_rb = 1'b1; nand_rb = 1'b0; nand_dq_in = 8'h5E;
        issue(18'h0_0010, 0, 8'h00);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(nand_ce_n && nand_re_n && !host_ready, "R9 data access stalled while busy", nand_ce_n, 1);
        end
        nand_rb = 1'b1;
        finish_access();
        verify(18'h0_0010, 0, 8'h00, 8'h5E);
        // R9 command store not stalled by busy
        nand_rb = 1'b0;
        access(18'h1_0000, 1, 8'hFF, 8'h00);
        // R9 busy ignored with mode off
        cfg_wait_rb = 1'b0;
        access(18'h0_0000, 1, 8'h42, 8'h00);
        nand_rb = 1'b1;

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [17:0] a;
            a = 18'($urandom);
            cfg_setup = 4'($urandom); cfg_strobe = 4'($urandom); cfg_hold = 4'($urandom);
            access(a, 1'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule